// File: doc/BRIEF.md
# Selectable-Interlock Request/Acknowledge Handshake Link

This block joins a requesting side and a responding side over an asynchronous request/acknowledge pair and a data bus. A one-cycle start pulse on the requesting side raises the request. The responding side sees the request and raises the acknowledge. While the acknowledge is high, it drives a word from its own data input onto the bus. Each side passes the other side's handshake wire through a two-flop synchronizer before it makes any state decision. The bus word travels through the same two stages as the acknowledge, so the requester captures it in step with the acknowledge it sees.

Three handshake disciplines are available, selected per transfer by the `mode` input. The encoding is 0 = open (no interlock), 1 = half interlock, 2 = full interlock, and 3 behaves as 2.

- In open mode the request is held for a fixed number of cycles and the acknowledge is not awaited.
- In half-interlock mode the request stays up until the acknowledge is seen, and the acknowledge drops on its own timer.
- In full-interlock mode each side drops its line only after it sees the other side's line change.

A `done` pulse on the requesting side closes each transfer. The two timer lengths are parameters in clock cycles.

Top module: `hs_link`

## Requirements
- R1: While `rst` is high and on the first cycles after it falls, `req`, `ack`, `done`, `bus_data` and `rdata` are all zero.
- R2: In mode 0, `req` stays high for exactly HOLD_CYC cycles whatever `ack` does, and `done` pulses in the same cycle that `req` falls.
- R3: In mode 1, `req` stays high until the synchronized acknowledge is seen, and falls exactly 3 cycles after `ack` rises.
- R4: In modes 0 and 1, `ack` stays high for exactly ACK_CYC cycles and then falls, whether or not `req` has fallen.
- R5: In modes 2 and 3, `req` falls exactly 3 cycles after `ack` rises, and never before the acknowledge has been seen.
- R6: In modes 2 and 3, `ack` stays high until the synchronized request has fallen, and falls exactly 3 cycles after `req` falls.
- R7: `done` is a one-cycle pulse. In mode 1 it comes in the cycle `req` falls. In modes 2 and 3 it comes exactly 3 cycles after `ack` falls.
- R8: `bus_data` carries the `src_data` word sampled when `ack` rises, holds it stable while `ack` is high, and is zero while `ack` is low. In modes 1, 2 and 3, `rdata` ends the transfer equal to that word.
- R9: A `start` pulse has no effect, and raises no second `req` edge, while a transfer is in progress or while the synchronized acknowledge is still high after `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Handshake discipline: 0 open, 1 half interlock, 2 or 3 full interlock |
| start | input | 1 | One-cycle pulse that begins a transfer |
| src_data | input | DW | Word the responding side presents |
| done | output | 1 | One-cycle pulse closing a transfer |
| rdata | output | DW | Word captured by the requesting side |
| req | output | 1 | Request wire, requester to responder |
| ack | output | 1 | Acknowledge wire, responder to requester |
| bus_data | output | DW | Data bus driven by the responder while the acknowledge is high |

## Verification
The hardest case to reach is the half-interlock race in which the acknowledge timer expires before the requester has seen the acknowledge. The requester must still capture the word and drop its request even though the raw `ack` is already low. The default ACK_CYC of 2 is shorter than the 3-cycle synchronizer round trip, so every half-interlock transfer in the vector table lands in that race.

A second case is a start pulse issued just after `done`, while the synchronized acknowledge is still high. The bench drives `start` at the first sample after `done` to hit that window. It then confirms at the ports that no new request edge appears.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {
    HS_OPEN = 2'd0,
    HS_HALF = 2'd1,
    HS_FULL = 2'd2
  } hs_mode_e;

  function automatic hs_mode_e hs_decode(input logic [1:0] m);
    case (m)
      2'd0:    return HS_OPEN;
      2'd1:    return HS_HALF;
      default: return HS_FULL;
    endcase
  endfunction
endpackage

// File: rtl/hs_sync2.sv
module hs_sync2 #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '0;
    else     stg[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '0;
      else     stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/hs_master.sv
module hs_master
  import hs_pkg::*;
#(
  parameter int DW       = 8,
  parameter int HOLD_CYC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode_i,
  input  logic          start_i,
  input  logic          ack_s_i,
  input  logic [DW-1:0] bus_s_i,
  output logic          req_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o
);
  localparam int HCW = $clog2(HOLD_CYC + 1);
  localparam logic [HCW-1:0] HOLD_LAST = HCW'(HOLD_CYC - 1);

  typedef enum logic [1:0] {M_IDLE, M_REQ, M_DROP} mst_e;
  mst_e st;
  hs_mode_e md;
  logic [HCW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= M_IDLE;
      md      <= HS_OPEN;
      cnt     <= '0;
      req_o   <= 1'b0;
      done_o  <= 1'b0;
      rdata_o <= '0;
    end else begin
      done_o <= 1'b0;
      case (st)
        M_IDLE: begin
          if (start_i && !ack_s_i) begin
            req_o <= 1'b1;
            md    <= hs_decode(mode_i);
            cnt   <= '0;
            st    <= M_REQ;
          end
        end
        M_REQ: begin
          case (md)
            HS_OPEN: begin
              if (cnt == HOLD_LAST) begin
                req_o  <= 1'b0;
                done_o <= 1'b1;
                st     <= M_IDLE;
              end else begin
                cnt <= cnt + 1'b1;
              end
            end
            HS_HALF: begin
              if (ack_s_i) begin
                req_o   <= 1'b0;
                done_o  <= 1'b1;
                rdata_o <= bus_s_i;
                st      <= M_IDLE;
              end
            end
            default: begin
              if (ack_s_i) begin
                req_o   <= 1'b0;
                rdata_o <= bus_s_i;
                st      <= M_DROP;
              end
            end
          endcase
        end
        M_DROP: begin
          if (!ack_s_i) begin
            done_o <= 1'b1;
            st     <= M_IDLE;
          end
        end
        default: st <= M_IDLE;
      endcase
    end
  end

  assert_half_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (st == M_REQ && md == HS_HALF && !ack_s_i) |=> req_o);
  assert_full_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (md == HS_FULL && $fell(req_o)) |-> $past(ack_s_i));
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  assert_start_gate_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(req_o) |-> $past(st) == M_IDLE);
endmodule

// File: rtl/hs_slave.sv
module hs_slave
  import hs_pkg::*;
#(
  parameter int DW      = 8,
  parameter int ACK_CYC = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode_i,
  input  logic          req_s_i,
  input  logic [DW-1:0] src_i,
  output logic          ack_o,
  output logic [DW-1:0] bus_o
);
  localparam int ACW = $clog2(ACK_CYC + 1);
  localparam logic [ACW-1:0] ACK_LAST = ACW'(ACK_CYC - 1);

  typedef enum logic [1:0] {S_IDLE, S_ACK, S_WAIT} slv_e;
  slv_e st;
  hs_mode_e md;
  logic [ACW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_IDLE;
      md    <= HS_OPEN;
      cnt   <= '0;
      ack_o <= 1'b0;
      bus_o <= '0;
    end else begin
      case (st)
        S_IDLE: begin
          if (req_s_i) begin
            ack_o <= 1'b1;
            bus_o <= src_i;
            md    <= hs_decode(mode_i);
            cnt   <= '0;
            st    <= S_ACK;
          end
        end
        S_ACK: begin
          if (md == HS_FULL) begin
            if (!req_s_i) begin
              ack_o <= 1'b0;
              bus_o <= '0;
              st    <= S_IDLE;
            end
          end else if (cnt == ACK_LAST) begin
            ack_o <= 1'b0;
            bus_o <= '0;
            st    <= S_WAIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_WAIT: begin
          if (!req_s_i) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_full_release_R6: assert property (@(posedge clk) disable iff (rst)
    (md == HS_FULL && $fell(ack_o)) |-> !$past(req_s_i));
  assert_timed_len_R4: assert property (@(posedge clk) disable iff (rst)
    (md != HS_FULL && ack_o) |-> (cnt <= ACK_LAST));
  assert_bus_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (ack_o && $past(ack_o)) |-> $stable(bus_o));
  assert_bus_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !ack_o |-> (bus_o == '0));
endmodule

// File: rtl/hs_link.sv
module hs_link #(
  parameter int DW       = 8,
  parameter int HOLD_CYC = 4,
  parameter int ACK_CYC  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    mode,
  input  logic          start,
  input  logic [DW-1:0] src_data,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic          req,
  output logic          ack,
  output logic [DW-1:0] bus_data
);
  logic          req_s;
  logic          ack_s;
  logic [DW-1:0] bus_s;
  logic [DW:0]   rsp_bundle_s;

  hs_sync2 #(.W(1), .STAGES(2)) u_req_sync (
    .clk(clk), .rst(rst), .d_i(req), .q_o(req_s)
  );

  hs_sync2 #(.W(DW + 1), .STAGES(2)) u_rsp_sync (
    .clk(clk), .rst(rst), .d_i({ack, bus_data}), .q_o(rsp_bundle_s)
  );

  assign ack_s = rsp_bundle_s[DW];
  assign bus_s = rsp_bundle_s[DW-1:0];

  hs_master #(.DW(DW), .HOLD_CYC(HOLD_CYC)) u_master (
    .clk(clk), .rst(rst), .mode_i(mode), .start_i(start),
    .ack_s_i(ack_s), .bus_s_i(bus_s),
    .req_o(req), .done_o(done), .rdata_o(rdata)
  );

  hs_slave #(.DW(DW), .ACK_CYC(ACK_CYC)) u_slave (
    .clk(clk), .rst(rst), .mode_i(mode), .req_s_i(req_s),
    .src_i(src_data), .ack_o(ack), .bus_o(bus_data)
  );
endmodule

// File: tb/hs_link_test.sv
module hs_link_test;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int HOLD = 4;
  localparam int ACKL = 2;
  localparam int NV = 6;
  localparam logic [9:0] VEC [NV] = '{
    {2'd0, 8'hA5}, {2'd1, 8'h3C}, {2'd2, 8'hC3},
    {2'd3, 8'h5A}, {2'd1, 8'hFF}, {2'd0, 8'h01}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode = 2'd0;
  logic start = 1'b0;
  logic [DW-1:0] src_data = '0;
  logic done, req, ack;
  logic [DW-1:0] rdata, bus_data;

  int tests = 0, fails = 0;
  int cyc = 0;
  int t_req_r, t_req_f, t_ack_r, t_ack_f, t_done;
  int n_req_rise = 0, bus_bad = 0;
  logic [DW-1:0] bus_at_ack;
  logic p_req = 1'b0, p_ack = 1'b0;

  hs_link #(.DW(DW), .HOLD_CYC(HOLD), .ACK_CYC(ACKL)) uut (
    .clk(clk), .rst(rst), .mode(mode), .start(start), .src_data(src_data),
    .done(done), .rdata(rdata), .req(req), .ack(ack), .bus_data(bus_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (req && !p_req) begin t_req_r <= cyc; n_req_rise <= n_req_rise + 1; end
    if (!req && p_req) t_req_f <= cyc;
    if (ack && !p_ack) begin t_ack_r <= cyc; bus_at_ack <= bus_data; end
    if (!ack && p_ack) t_ack_f <= cyc;
    if (done) t_done <= cyc;
    if (!ack && bus_data != '0) bus_bad <= bus_bad + 1;
    p_req <= req;
    p_ack <= ack;
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic kick(input logic [1:0] m, input logic [DW-1:0] d);
    mode = m;
    src_data = d;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      if (done) break;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    chk(req == 0 && ack == 0 && done == 0, "R1 lines in reset", {req, ack, done}, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(req == 0 && ack == 0 && done == 0, "R1 lines after reset", {req, ack, done}, 0);
    chk(bus_data == 0, "R1 bus after reset", bus_data, 0);
    chk(rdata == 0, "R1 rdata after reset", rdata, 0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] m;
      logic [DW-1:0] d;
      m = VEC[i][9:8];
      d = VEC[i][7:0];
      base = n_req_rise;
      kick(m, d);
      wait_done();
      repeat (12) @(negedge clk);
      chk(n_req_rise - base == 1, "R9 one request edge", n_req_rise - base, 1);
      chk(bus_at_ack == d, "R8 bus word at ack", bus_at_ack, d);
      if (m == 2'd0) begin
        chk(t_req_f - t_req_r == HOLD, "R2 open hold length", t_req_f - t_req_r, HOLD);
        chk(t_done == t_req_f, "R2 done at release", t_done, t_req_f);
        chk(t_ack_f - t_ack_r == ACKL, "R4 open ack length", t_ack_f - t_ack_r, ACKL);
      end else if (m == 2'd1) begin
        chk(t_req_f - t_ack_r == 3, "R3 half req fall after ack", t_req_f - t_ack_r, 3);
        chk(t_ack_f - t_ack_r == ACKL, "R4 half ack length", t_ack_f - t_ack_r, ACKL);
        chk(t_ack_f < t_req_f, "R4 ack falls before req", t_ack_f, t_req_f);
        chk(t_done == t_req_f, "R7 half done at req fall", t_done, t_req_f);
        chk(rdata == d, "R8 half rdata", rdata, d);
      end else begin
        chk(t_req_f - t_ack_r == 3, "R5 full req fall after ack", t_req_f - t_ack_r, 3);
        chk(t_ack_f - t_req_f == 3, "R6 full ack fall after req", t_ack_f - t_req_f, 3);
        chk(t_done - t_ack_f == 3, "R7 full done after ack fall", t_done - t_ack_f, 3);
        chk(rdata == d, "R8 full rdata", rdata, d);
      end
    end

    // R9: extra start during a full-interlock transfer
    base = n_req_rise;
    kick(2'd2, 8'h77);
    repeat (3) @(negedge clk);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done();
    repeat (12) @(negedge clk);
    chk(n_req_rise - base == 1, "R9 start while busy ignored", n_req_rise - base, 1);
    chk(rdata == 8'h77, "R8 rdata after busy start", rdata, 8'h77);

    // R9: start right after done while synchronized ack still high
    kick(2'd1, 8'h42);
    wait_done();
    start = 1'b1; @(negedge clk); start = 1'b0;
    base = n_req_rise;
    repeat (12) @(negedge clk);
    chk(n_req_rise == base, "R9 start with stale ack ignored", n_req_rise - base, 0);
    chk(req == 1'b0, "R9 req idle after stale start", req, 0);

    chk(bus_bad == 0, "R8 bus zero while ack low", bus_bad, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule